// File: doc/BRIEF.md
# Packed-BCD Accumulator Correction Unit

This block holds an 8-bit accumulator and its flag byte. On request it corrects the accumulator to a valid two-digit packed-BCD value after a binary add or subtract. The correction is chosen by the subtract, half-carry and carry flags held in the flag byte. The zero, half-carry and carry flags are then updated, and the subtract flag is kept as it was.

The same register pair can also be loaded in one step from a 16-bit word, as a stack pop would deliver it. The high byte goes to the accumulator and the low byte to the flags. The four unused flag bits are always forced to zero on this load.

Commands arrive on a valid/ready port. `cmd_ready` is high whenever reset is low, so the unit accepts one command on every cycle and never applies back-pressure. While reset is high, `cmd_ready` is low and nothing is accepted. A command is accepted on the rising edge where `cmd_valid` and `cmd_ready` are both high. The registers take their new value on that same edge, and `done` is high for exactly the following cycle. There is no output handshake: `acc_q` and `flags_q` always show the current register contents.

Top module: `bcd_adjust_unit`

## Requirements
- R1: The flag byte places zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4. Bits 3 to 0 always read as 0.
- R2: In add mode (subtract flag 0), if carry is 1 or the accumulator is above 0x99, the unit adds 0x60 and sets carry to 1.
- R3: In add mode, if half-carry is 1 or the low nibble is above 9, the unit adds 0x06. The nibble test is made on the value after any 0x60 step.
- R4: In subtract mode (subtract flag 1), the unit subtracts 0x60 when carry is 1 and subtracts 0x06 when half-carry is 1. Carry keeps its value and no range test is made.
- R5: All corrections wrap modulo 256. In add mode, an adjust never clears carry.
- R6: Every adjust clears half-carry. The incoming half-carry value still controls the correction, so 0x00 with half-carry 1 gives 0x06.
- R7: After an adjust, zero is 1 exactly when the 8-bit result is 0x00.
- R8: An adjust leaves the subtract flag unchanged.
- R9: A pop load (`cmd_pop`=1) sets the accumulator to `cmd_word[15:8]` and the flags to `cmd_word[7:0]` AND 0xF0.
- R10: An accepted command updates the registers on its accepting edge, and `done` is 1 for only the next cycle. With no accepted command, `done` stays 0 and the registers hold their value.
- R11: A synchronous active-high reset clears the accumulator and all flags, and drives `done` and `cmd_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High when a command can be taken (whenever reset is low) |
| cmd_pop | input | 1 | 1 = load the pair from `cmd_word`, 0 = decimal adjust |
| cmd_word | input | 16 | Popped word: accumulator in the high byte, flags in the low byte |
| done | output | 1 | One-cycle pulse after an accepted command |
| acc_q | output | 8 | Accumulator register |
| flags_q | output | 8 | Flag register (Z,N,H,C in bits 7..4) |

## Verification
First, three fixed add-mode values are tried: 0x0A, 0x9A, and 0x00 with half-carry set. They separate the low-nibble step, the combined high and low steps that wrap to zero, and the case where half-carry is sampled before it is cleared. Hand-picked subtract-mode cases then separate the 0x60, 0x06 and combined decrements, and show that carry is kept. A pop word with all low bits set shows the mask. Finally, every accumulator value is swept with every flag combination. This covers the range boundaries at 0x99/0x9A and 0x?9/0x?A, as well as wrap-around at 0xFF.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
  localparam int ACC_W   = 8;
  localparam int FLG_W   = 8;
  localparam int WORD_W  = ACC_W + FLG_W;
  localparam int FB_Z    = 7;
  localparam int FB_N    = 6;
  localparam int FB_H    = 5;
  localparam int FB_C    = 4;
  localparam logic [FLG_W-1:0] FLAG_MASK = 8'hF0;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  function automatic logic [FLG_W-1:0] pack_flags(flags_t f);
    logic [FLG_W-1:0] b;
    b       = '0;
    b[FB_Z] = f.z;
    b[FB_N] = f.n;
    b[FB_H] = f.h;
    b[FB_C] = f.c;
    return b;
  endfunction
endpackage

// File: rtl/bcd_adj_core.sv
module bcd_adj_core
  import bcd_adj_pkg::*;
(
  input  logic [ACC_W-1:0] acc_i,
  input  logic             n_i,
  input  logic             h_i,
  input  logic             c_i,
  output logic [ACC_W-1:0] acc_o,
  output flags_t           flg_o
);
  localparam logic [ACC_W-1:0] HI_STEP = 8'h60;
  localparam logic [ACC_W-1:0] LO_STEP = 8'h06;
  localparam logic [ACC_W-1:0] HI_LIM  = 8'h99;
  localparam logic [3:0]       LO_LIM  = 4'd9;

  logic             hi_fix;
  logic             lo_fix;
  logic [ACC_W-1:0] mid;
  logic [ACC_W-1:0] res;

  always_comb begin
    if (!n_i) begin
      hi_fix = c_i || (acc_i > HI_LIM);
      mid    = acc_i + (hi_fix ? HI_STEP : '0);
      lo_fix = h_i || (mid[3:0] > LO_LIM);
      res    = mid + (lo_fix ? LO_STEP : '0);
    end else begin
      hi_fix = c_i;
      mid    = acc_i - (hi_fix ? HI_STEP : '0);
      lo_fix = h_i;
      res    = mid - (lo_fix ? LO_STEP : '0);
    end
    acc_o   = res;
    flg_o.z = (res == '0);
    flg_o.n = n_i;
    flg_o.h = 1'b0;
    flg_o.c = n_i ? c_i : (c_i || hi_fix);
  end

  // R5: in add mode a set carry is never cleared
  always_comb begin
    a_r5_carry_kept: assert (n_i || !c_i || flg_o.c);
  end
endmodule

// File: rtl/bcd_adj_regpair.sv
module bcd_adj_regpair
  import bcd_adj_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_adj,
  input  logic [ACC_W-1:0]  adj_acc,
  input  flags_t            adj_flg,
  input  logic              wr_pop,
  input  logic [WORD_W-1:0] pop_word,
  output logic [ACC_W-1:0]  acc_q,
  output logic [FLG_W-1:0]  flag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      flag_q <= '0;
    end else if (wr_pop) begin
      acc_q  <= pop_word[WORD_W-1:FLG_W];
      flag_q <= pop_word[FLG_W-1:0] & FLAG_MASK;
    end else if (wr_adj) begin
      acc_q  <= adj_acc;
      flag_q <= pack_flags(adj_flg);
    end
  end

  // R1: unused flag bits stay zero
  a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    flag_q[3:0] == 4'h0);
  // R9: pop loads the accumulator from the high byte
  a_r9_pop_acc: assert property (@(posedge clk) disable iff (rst)
    wr_pop |=> acc_q == $past(pop_word[WORD_W-1:FLG_W]));
  // R10: registers hold without a write
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_pop && !wr_adj) |=> ($stable(acc_q) && $stable(flag_q)));
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcd_adj_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_pop,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              done,
  output logic [ACC_W-1:0]  acc_q,
  output logic [FLG_W-1:0]  flags_q
);
  logic             fire;
  logic [ACC_W-1:0] core_acc;
  flags_t           core_flg;

  assign cmd_ready = ~rst;
  assign fire      = cmd_valid & cmd_ready;

  bcd_adj_core u_core (
    .acc_i (acc_q),
    .n_i   (flags_q[FB_N]),
    .h_i   (flags_q[FB_H]),
    .c_i   (flags_q[FB_C]),
    .acc_o (core_acc),
    .flg_o (core_flg)
  );

  bcd_adj_regpair u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_adj   (fire & ~cmd_pop),
    .adj_acc  (core_acc),
    .adj_flg  (core_flg),
    .wr_pop   (fire & cmd_pop),
    .pop_word (cmd_word),
    .acc_q    (acc_q),
    .flag_q   (flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= fire;
  end

  // R10: done follows an accepted command by one cycle only
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    fire |=> done);
  a_r10_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !done);
  // R6: half-carry is clear after an adjust
  a_r6_half_cleared: assert property (@(posedge clk) disable iff (rst)
    (fire && !cmd_pop) |=> !flags_q[FB_H]);
  // R8: subtract flag survives an adjust
  a_r8_sub_kept: assert property (@(posedge clk) disable iff (rst)
    (fire && !cmd_pop) |=> flags_q[FB_N] == $past(flags_q[FB_N]));
  // R7: zero flag matches the result after an adjust
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (fire && !cmd_pop) |=> flags_q[FB_Z] == (acc_q == '0));
  // R4: carry is unchanged by a subtract-mode adjust
  a_r4_sub_carry: assert property (@(posedge clk) disable iff (rst)
    (fire && !cmd_pop && flags_q[FB_N]) |=> flags_q[FB_C] == $past(flags_q[FB_C]));
  // R11: reset clears the pair
  a_r11_reset: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && flags_q == '0 && !done));
endmodule

// File: tb/bcd_adjust_unit_bench.sv
`timescale 1ns/1ps
module bcd_adjust_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_pop = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        done;
  logic [7:0]  acc_q;
  logic [7:0]  flags_q;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] acc;
    logic [7:0] flg;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] m_acc = '0;
  logic [7:0] m_flg = '0;

  always #2.5 clk = ~clk;

  bcd_adjust_unit u_bcd_adjust_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_pop(cmd_pop), .cmd_word(cmd_word), .done(done),
    .acc_q(acc_q), .flags_q(flags_q)
  );

  // Model written from R2..R8: Z=bit7 N=bit6 H=bit5 C=bit4
  function automatic logic [15:0] model_adj(logic [7:0] a, logic [7:0] f);
    logic n, h, c, z;
    logic [7:0] v;
    n = f[6]; h = f[5]; c = f[4];
    v = a;
    if (!n) begin
      if (c || v > 8'h99) begin v = v + 8'h60; c = 1'b1; end
      if (h || v[3:0] > 4'd9) v = v + 8'h06;
    end else begin
      if (c) v = v - 8'h60;
      if (h) v = v - 8'h06;
    end
    z = (v == 8'h00);
    return {v, z, n, 1'b0, c, 4'h0};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic drive(logic pop, logic [15:0] w, string tag);
    logic [15:0] r;
    exp_t e;
    if (pop) begin
      m_acc = w[15:8];
      m_flg = w[7:0] & 8'hF0;
    end else begin
      r = model_adj(m_acc, m_flg);
      m_acc = r[15:8];
      m_flg = r[7:0];
    end
    e.acc = m_acc; e.flg = m_flg; e.tag = tag;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_pop = pop; cmd_word = w;
    sb.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic fixed_case(logic [15:0] w, logic [7:0] ea, logic [7:0] ef, string tag);
    drive(1'b1, w, "R9");
    drive(1'b0, 16'h0, tag);
    @(negedge clk);
    check({tag, " acc"}, acc_q, ea);
    check({tag, " flags"}, flags_q, ef);
  endtask

  // Monitor: compare every done pulse with the scoreboard head (R10)
  always begin
    @(posedge clk);
    #1;
    if (!rst && !finished && done) begin
      if (sb.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R10 actual=done expected=idle");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " acc"}, acc_q, e.acc);
        check({e.tag, " flags"}, flags_q, e.flg);
      end
    end
  end

  initial begin
    #150000;
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 acc", acc_q, 8'h00);
    check("R11 flags", flags_q, 8'h00);
    check("R11 ready", {7'b0, cmd_ready}, 8'h00);
    check("R11 done", {7'b0, done}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R10 ready", {7'b0, cmd_ready}, 8'h01);

    // add mode
    fixed_case(16'h0A00, 8'h10, 8'h00, "R3 0x0A");
    fixed_case(16'h9A00, 8'h00, 8'h90, "R2 R7 0x9A");
    fixed_case(16'h0020, 8'h06, 8'h00, "R6 H in");
    fixed_case(16'h0010, 8'h60, 8'h10, "R5 carry kept");
    fixed_case(16'hFF00, 8'h65, 8'h10, "R5 wrap FF");
    fixed_case(16'h9900, 8'h99, 8'h00, "R2 0x99 edge");
    // subtract mode
    fixed_case(16'h0070, 8'h9A, 8'h50, "R4 sub both");
    fixed_case(16'h4540, 8'h45, 8'h40, "R8 sub none");
    fixed_case(16'h0660, 8'h00, 8'hC0, "R4 R7 sub H");
    fixed_case(16'hA050, 8'h40, 8'h50, "R4 sub C");
    // pop mask
    drive(1'b1, 16'h12FF, "R9 mask");
    @(negedge clk);
    check("R1 flags", flags_q, 8'hF0);

    // idle: nothing changes, no done
    repeat (5) @(negedge clk);
    check("R10 hold acc", acc_q, 8'h12);
    check("R10 hold flags", flags_q, 8'hF0);

    // full sweep
    for (int a = 0; a < 256; a++) begin
      for (int f = 0; f < 16; f++) begin
        drive(1'b1, {a[7:0], f[3:0], 4'hF}, "R9 sweep");
        drive(1'b0, 16'h0, "R2 R3 R4 sweep");
      end
    end
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R10 actual=%0d pending expected=0", sb.size());
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule